// File: doc/BRIEF.md
# Burst-Four Write Port with Byte Masking

This block is the write half of a separate-port burst memory. A request is taken with the address on a rising edge of the primary clock K. Starting one K rise later, the port captures four data words on four consecutive half-cycle edges: K rise, then K# rise, then K rise, then K# rise. Each word brings its own pair of active-low byte-write selects. The four words are assembled into one 72-bit burst. That burst is written into the array at the captured address in a single update, on the edge after the fourth word. Byte lanes whose select was high keep their old contents.

Both clock phases are modelled by one clock `clk` running at twice the K rate. An internal phase bit marks which edges are K rises. A second request on the K rise straight after an accepted one is dropped. Requests spaced every other K rise overlap with the burst in flight, so a word can enter on every edge. A combinational observation port `rd_addr`/`rd_data` exposes the array contents so that merged results can be examined. It is not a timed read path.

Top module: `qburst_wr_port`

## Requirements
- R1: A request is accepted only on a K-rise edge, that is an even edge of `clk` counted from 0 after reset release, with `wr_n` low. `wr_n` low on an odd (K#) edge is ignored, and the data that follows writes nothing.
- R2: The first data word of an accepted request is captured on the next K-rise edge, two `clk` edges after acceptance. Words 1 to 3 are captured on the three edges that follow. Word k occupies bits 18k+17:18k of the 72-bit burst, so word 0 is the lowest.
- R3: The array is updated on the `clk` edge after the fourth word is captured, and not before. After the edge that captures word 3, `rd_data` still shows the old value. After the next edge it shows the merged value.
- R4: A request on the K rise immediately after an accepted request is dropped, and its address is not written. Requests every other K rise are all accepted, and their data streams without gaps.
- R5: For each word, `bw_n[0]` low enables bits 8:0 and `bw_n[1]` low enables bits 17:9. A lane whose select is high keeps its previous array contents.
- R6: With no request pending, `din` and `bw_n` have no effect on the array.
- R7: While `rst_n` is low, no request is accepted and the array is not written. After release, the port is idle and edge 0 is a K rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; even edges after reset are K rises, odd edges K# rises |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_n | input | 1 | Active-low write request, sampled on K rises |
| addr | input | AW | Burst address, taken with an accepted request |
| din | input | WORD_W | Data word, one per edge during capture |
| bw_n | input | 2 | Active-low byte-write selects for the current word |
| rd_addr | input | AW | Observation address |
| rd_data | output | 4*WORD_W | Array contents at `rd_addr` (combinational) |

## Verification
The bound checker enforces the control sequencing on every cycle:
- requests are accepted only on K rises;
- the first word always follows on the next K rise;
- the K rise after acceptance never opens a new request;
- the commit fires exactly once, one edge after the fourth word;
- capture storage holds still when no burst is active.

Only the bench's scenarios show what actually lands in the array. It sweeps all 256 lane masks across every address and checks the merged values against an arithmetic model. It also covers the old/new boundary around the commit edge, dropped back-to-back and K# requests, idle noise, and requests held during reset.

// File: rtl/qburst_wr_port.sv
module qburst_wr_port #(
  parameter int AW     = 4,
  parameter int WORD_W = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_n,
  input  logic [AW-1:0]         addr,
  input  logic [WORD_W-1:0]     din,
  input  logic [1:0]            bw_n,
  input  logic [AW-1:0]         rd_addr,
  output logic [4*WORD_W-1:0]   rd_data
);
  localparam int BEATS   = 4;
  localparam int LANE_W  = WORD_W / 2;
  localparam int LANES   = 2 * BEATS;
  localparam int BURST_W = BEATS * WORD_W;
  localparam int DEPTH   = 1 << AW;

  logic                       phase, req_pend, cap_act, commit_v;
  logic [1:0]                 cnt;
  logic [AW-1:0]              req_addr, cap_addr, commit_addr;
  logic [(BEATS-1)*WORD_W-1:0] wdata;
  logic [2*(BEATS-1)-1:0]     wmask;
  logic [BURST_W-1:0]         commit_data;
  logic [LANES-1:0]           commit_mask;
  logic [BURST_W-1:0]         mem [DEPTH];

  wire accept = !phase && !wr_n && !req_pend;
  wire first  = !phase && req_pend;
  wire last   = cap_act && (cnt == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= 1'b0;
      req_pend <= 1'b0;
      req_addr <= '0;
      cap_act  <= 1'b0;
      cnt      <= '0;
      cap_addr <= '0;
      commit_v <= 1'b0;
    end else begin
      phase    <= ~phase;
      commit_v <= last;
      if (accept) begin
        req_pend <= 1'b1;
        req_addr <= addr;
      end else if (first) begin
        req_pend <= 1'b0;
      end
      if (first) begin
        cap_act  <= 1'b1;
        cnt      <= 2'd1;
        cap_addr <= req_addr;
      end else if (cap_act) begin
        cnt <= cnt + 2'd1;
        if (last) cap_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (first) begin
      wdata[WORD_W-1:0] <= din;
      wmask[1:0]        <= ~bw_n;
    end else if (cap_act && !last) begin
      wdata[int'(cnt)*WORD_W +: WORD_W] <= din;
      wmask[int'(cnt)*2 +: 2]           <= ~bw_n;
    end
    if (last) begin
      commit_data <= {din, wdata};
      commit_mask <= {~bw_n, wmask};
      commit_addr <= cap_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (commit_v) begin
      for (int l = 0; l < LANES; l++) begin
        if (commit_mask[l])
          mem[commit_addr][l*LANE_W +: LANE_W] <= commit_data[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

module qburst_wr_port_chk #(
  parameter int AW     = 4,
  parameter int WORD_W = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_n,
  input logic                    phase,
  input logic                    req_pend,
  input logic                    cap_act,
  input logic [1:0]              cnt,
  input logic                    commit_v,
  input logic [3*WORD_W-1:0]     wdata
);
  AST_ACCEPT_ON_K_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_pend) |-> ($past(phase) == 1'b0 && $past(wr_n) == 1'b0)); // R1

  AST_FIRST_WORD_NEXT_K: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pend && !phase) |=> (cap_act && cnt == 2'd1)); // R2

  AST_DROP_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pend && !phase) |=> !req_pend); // R4

  AST_COMMIT_AFTER_FOURTH: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_act && cnt == 2'd3) |=> commit_v); // R3

  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_v |=> !commit_v); // R3

  AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_act && !(req_pend && !phase)) |=> $stable(wdata)); // R6
endmodule

bind qburst_wr_port qburst_wr_port_chk #(.AW(AW), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .phase(phase), .req_pend(req_pend),
  .cap_act(cap_act), .cnt(cnt), .commit_v(commit_v), .wdata(wdata)
);

// File: tb/tb_qburst_wr_port.sv
`timescale 1ns/1ps
module tb_qburst_wr_port;
  localparam int AW = 4, WW = 18, N = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, wr_n = 1'b1;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic [WW-1:0] din = '0;
  logic [1:0] bw_n = 2'b11;
  logic [4*WW-1:0] rd_data;

  qburst_wr_port #(.AW(AW), .WORD_W(WW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .din(din),
    .bw_n(bw_n), .rd_addr(rd_addr), .rd_data(rd_data));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, tslot = 0;
  logic [4*WW-1:0] ref_mem [N];
  logic [AW-1:0] b_addr [16];
  logic [7:0]    b_mask [16];
  int            b_id   [16];

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [WW-1:0] dgen(int i, int k);
    return WW'((i * 40503 + k * 2731 + 977) ^ (i << 5) ^ (k << 13));
  endfunction

  task automatic chk(string req, logic [4*WW-1:0] act, logic [4*WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic slot(logic w, logic [AW-1:0] a, logic [WW-1:0] d, logic [1:0] b);
    wr_n = w; addr = a; din = d; bw_n = b;
    @(posedge clk); @(negedge clk);
    tslot++;
  endtask

  task automatic align_k();
    if (tslot % 2 != 0) slot(1'b1, '0, '0, 2'b11);
  endtask

  task automatic merge(int id, logic [AW-1:0] a, logic [7:0] m);
    logic [4*WW-1:0] nd;
    for (int k = 0; k < 4; k++) nd[k*WW +: WW] = dgen(id, k);
    for (int l = 0; l < 8; l++)
      if (m[l]) ref_mem[a][l*9 +: 9] = nd[l*9 +: 9];
  endtask

  // pipelined bursts: requests on every other K rise
  task automatic run_bursts(int n);
    align_k();
    for (int t = 0; t <= 4 * n + 2; t++) begin
      logic w; logic [WW-1:0] d; logic [1:0] b;
      w = 1'b1; d = '0; b = 2'b11;
      if (t % 4 == 0 && t / 4 < n) w = 1'b0;
      if (t >= 2 && (t - 2) / 4 < n) begin
        d = dgen(b_id[(t-2)/4], (t-2) % 4);
        b = ~b_mask[(t-2)/4][((t-2)%4)*2 +: 2];
      end
      slot(w, (t / 4 < n) ? b_addr[t/4] : '0, d, b);
    end
    for (int j = 0; j < n; j++) merge(b_id[j], b_addr[j], b_mask[j]);
  endtask

  task automatic check_all(string req);
    for (int a = 0; a < N; a++) begin
      rd_addr = AW'(a); #0.1;
      chk(req, rd_data, ref_mem[a]);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1; tslot = 0;

    // R2 R4: full-mask fill of every address, back-to-back bursts
    for (int a = 0; a < N; a++) begin
      b_addr[a] = AW'(a); b_mask[a] = 8'hFF; b_id[a] = 1000 + a;
    end
    run_bursts(N);
    check_all("R2/R4 fill");

    // R5: all 256 lane masks across all addresses
    for (int g = 0; g < 16; g++) begin
      for (int a = 0; a < N; a++) begin
        b_addr[a] = AW'((a + g) % N); b_mask[a] = 8'(g * 16 + a); b_id[a] = g * 16 + a;
      end
      run_bursts(N);
      check_all("R5 mask sweep");
    end

    // R3: commit boundary
    begin
      logic [4*WW-1:0] old;
      align_k();
      rd_addr = 4'd5; old = ref_mem[5];
      slot(1'b0, 4'd5, '0, 2'b11);
      slot(1'b1, '0, '0, 2'b11);
      for (int k = 0; k < 4; k++) slot(1'b1, '0, dgen(777, k), 2'b00);
      chk("R3 before commit", rd_data, old);
      slot(1'b1, '0, '0, 2'b11);
      merge(777, 4'd5, 8'hFF);
      chk("R3 after commit", rd_data, ref_mem[5]);
    end

    // R4: request on the very next K rise is dropped
    align_k();
    slot(1'b0, 4'd2, '0, 2'b11);
    slot(1'b1, '0, '0, 2'b11);
    slot(1'b0, 4'd9, dgen(555, 0), 2'b00);
    for (int k = 1; k < 4; k++) slot(1'b1, '0, dgen(555, k), 2'b00);
    for (int k = 0; k < 6; k++) slot(1'b1, '0, 18'h3FFFF, 2'b00);
    merge(555, 4'd2, 8'hFF);
    rd_addr = 4'd9; #0.1; chk("R4 dropped addr", rd_data, ref_mem[9]);
    rd_addr = 4'd2; #0.1; chk("R4 accepted addr", rd_data, ref_mem[2]);

    // R1: request on a K# edge ignored
    align_k();
    slot(1'b1, '0, '0, 2'b11);
    slot(1'b0, 4'd7, '0, 2'b00);
    for (int k = 0; k < 8; k++) slot(1'b1, '0, dgen(333, k), 2'b00);
    check_all("R1 K# request");

    // R6: idle noise
    for (int k = 0; k < 20; k++) slot(1'b1, AW'(k), dgen(444, k), 2'(k));
    check_all("R6 idle");

    // R7: requests held during reset
    rst_n = 1'b0;
    for (int k = 0; k < 10; k++) slot(1'b0, AW'(k), dgen(666, k), 2'b00);
    wr_n = 1'b1; rst_n = 1'b1; tslot = 0;
    for (int k = 0; k < 8; k++) slot(1'b1, '0, '0, 2'b11);
    check_all("R7 reset");

    // R7: edge 0 after release is a K rise
    slot(1'b0, 4'd11, '0, 2'b11);
    slot(1'b1, '0, '0, 2'b11);
    for (int k = 0; k < 4; k++) slot(1'b1, '0, dgen(888, k), 2'b00);
    slot(1'b1, '0, '0, 2'b11);
    merge(888, 4'd11, 8'hFF);
    rd_addr = 4'd11; #0.1; chk("R7 first edge is K", rd_data, ref_mem[11]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule